// File: doc/BRIEF.md
# Dual-Format Host Bus Slave Interface

This block lets an external 8-bit processor read and write a bank of sixteen byte-wide registers over a parallel bus. The bus can be wired in either of two ways. In the multiplexed arrangement, address and data share eight lines, and an address-latch strobe marks the address phase. In the separate arrangement, a 4-bit address port sits beside an 8-bit data port. The arrangement is chosen once, while reset is held, from the level on a configuration pin. That pin has a pull-up, so the bench drives it high to model a pin left open. After reset the same pin can serve as an active-low interrupt output.

Two strobe conventions are supported. The split convention uses an active-low read line and an active-low write line. The direction convention uses an active-high data strobe and a read/write direction line. In the separate arrangement, the address-latch pin has no latching job, so it selects the convention instead. In the multiplexed arrangement, a static configuration input selects it. The block resynchronises all bus pins to its clock. It issues a one-cycle register write enable once per write access, and it drives read data together with an output enable for the external tristate buffer.

Top module: `dual_bus_host_if`

## Requirements
- R1: While `rst_n` is low, `mode_pin_i` is sampled. Low selects the multiplexed arrangement; high selects the separate arrangement.
- R2: Every assertion of `rst_n` re-samples `mode_pin_i`, so a later reset can change the arrangement.
- R3: In the separate arrangement, `addr_i[3:0]` selects one of the 16 registers for both reads and writes.
- R4: In the multiplexed arrangement, the address is captured from `ad_i[3:0]` while `ale_fmt_i` is high. It is held after `ale_fmt_i` falls, and `ad_i[7:4]` of the address byte is ignored.
- R5: In the separate arrangement, `ale_fmt_i`=1 selects the split convention: `rd_ds_i` low means read and `wr_rw_i` low means write.
- R6: In the separate arrangement, `ale_fmt_i`=0 selects the direction convention: `rd_ds_i` high is the strobe, `wr_rw_i`=1 reads and `wr_rw_i`=0 writes.
- R7: While `cs_n_i` is high, no write enable is issued and `ad_oe_o` stays low.
- R8: Each write access gives exactly one single-cycle pulse on `reg_wr_en_o`, after the write condition ends. It carries the address and data present while the condition was active.
- R9: `ad_oe_o` is high only while chip select and the read condition are both active. `ad_o` then carries byte `reg_rd_vec_i[8*a +: 8]` for the selected address `a`.
- R10: `irq_oe_o` is low during reset and always low in the multiplexed arrangement. In the separate arrangement it follows `irq_en_i`, and `irq_o` is the inverse of `irq_req_i`.
- R11: In the multiplexed arrangement the convention comes from `mux_fmt_split_i` (1 split, 0 direction), whatever level `ale_fmt_i` has.
- R12: At most one bit of `reg_wr_en_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pin sampled while low |
| mode_pin_i | input | 1 | Arrangement select level (low = multiplexed) |
| irq_en_i | input | 1 | Allows the mode pin to be driven as interrupt |
| irq_req_i | input | 1 | Interrupt request from the register side |
| mux_fmt_split_i | input | 1 | Strobe convention in multiplexed arrangement |
| cs_n_i | input | 1 | Chip select, active low |
| ale_fmt_i | input | 1 | Address latch (multiplexed) or convention select (separate) |
| rd_ds_i | input | 1 | Read strobe (low) or data strobe (high) |
| wr_rw_i | input | 1 | Write strobe (low) or direction (1 read) |
| addr_i | input | 4 | Address port, separate arrangement |
| ad_i | input | 8 | Incoming data, or address/data when multiplexed |
| ad_o | output | 8 | Read data toward the bus |
| ad_oe_o | output | 1 | Bus output enable |
| irq_o | output | 1 | Active-low interrupt level for the mode pin |
| irq_oe_o | output | 1 | Drive enable for the mode pin |
| reg_wr_en_o | output | 16 | One-hot register write enable |
| reg_wr_data_o | output | 8 | Register write data |
| reg_rd_vec_i | input | 128 | All register contents, byte n at bits 8n+7:8n |

## Verification
The hardest situation to reach is a change of arrangement from one reset to the next. To reach it, the mode pin must hold different levels across separate reset pulses, and the test must then show that the address decode, the source of the strobe convention and the interrupt pin all follow the new choice. The stimulus starts in the separate arrangement. It then resets into the multiplexed arrangement, with interrupts still enabled and the latch pin low. A later reset returns to the separate arrangement. A multiplexed address byte with nonzero upper bits checks that only four address bits are decoded.

// File: rtl/hbi_pkg.sv
// Shared widths and types for the dual-format host bus interface.
package hbi_pkg;
    localparam int HBI_DATA_W = 8;
    localparam int HBI_ADDR_W = 4;
    localparam int HBI_NREG   = 1 << HBI_ADDR_W;

    // Strobe convention in use on the host side.
    typedef enum logic {
        STB_DIR   = 1'b0,   // data strobe plus read/write direction
        STB_SPLIT = 1'b1    // separate active-low read and write strobes
    } strobe_fmt_e;
endpackage

// File: rtl/hbi_sync.sv
// Multi-stage resynchroniser for a bundle of host pins.
// Assumes multi-bit fields (address, data) are held stable by the host
// for longer than STAGES cycles around each strobe.
module hbi_sync #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= d_i;
                end
            end else begin : g_next
                // Later stages shift the value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hbi_mode_ctl.sv
// Arrangement and convention control.
// Samples the mode pin during reset, selects the strobe convention, and
// drives the interrupt function of the mode pin in the separate arrangement.
// Assumes the mode pin is stable for the final reset cycle.
module hbi_mode_ctl
    import hbi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_pin_i,
    input  logic        irq_en_i,
    input  logic        irq_req_i,
    input  logic        mux_fmt_split_i,
    input  logic        fmt_pin_s_i,
    output logic        mux_mode_o,
    output strobe_fmt_e fmt_o,
    output logic        irq_o,
    output logic        irq_oe_o
);
    logic mux_q;
    logic irq_q;
    logic irq_oe_q;

    // Latch the arrangement while reset is held; hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) mux_q <= ~mode_pin_i;
    end

    // Register the interrupt drive; never drive during reset or when multiplexed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_oe_q <= 1'b0;
            irq_q    <= 1'b1;
        end else begin
            irq_oe_q <= ~mux_q & irq_en_i;
            irq_q    <= ~irq_req_i;
        end
    end

    // Pick the convention source according to the arrangement.
    always_comb begin
        if (mux_q) fmt_o = mux_fmt_split_i ? STB_SPLIT : STB_DIR;
        else       fmt_o = fmt_pin_s_i     ? STB_SPLIT : STB_DIR;
    end

    assign mux_mode_o = mux_q;
    assign irq_o      = irq_q;
    assign irq_oe_o   = irq_oe_q;
endmodule

// File: rtl/hbi_addr_sel.sv
// Register address selection.
// Multiplexed: captures the low address bits from the shared bus while the
// latch strobe is high. Separate: passes the dedicated address port.
module hbi_addr_sel #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_mode_i,
    input  logic              ale_s_i,
    input  logic [ADDR_W-1:0] ad_lo_s_i,
    input  logic [ADDR_W-1:0] addr_s_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] lat_q;

    // Capture the address phase of a multiplexed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                     lat_q <= '0;
        else if (mux_mode_i && ale_s_i) lat_q <= ad_lo_s_i;
    end

    // Choose the address source for the current arrangement.
    always_comb begin
        addr_o = mux_mode_i ? lat_q : addr_s_i;
    end
endmodule

// File: rtl/hbi_strobe_dec.sv
// Strobe decoding and write-completion detection.
// Derives read and write conditions for either convention. It captures the
// address and data while a write is active, and flags the cycle in which
// the write condition ends.
module hbi_strobe_dec
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_fmt_e       fmt_i,
    input  logic              cs_n_s_i,
    input  logic              rd_s_i,
    input  logic              wr_s_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              rd_act_o,
    output logic              wr_done_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    logic              wr_act;
    logic              wr_act_q;
    logic [ADDR_W-1:0] wa_q;
    logic [DATA_W-1:0] wd_q;

    // Decode the current read and write conditions.
    always_comb begin
        if (fmt_i == STB_SPLIT) begin
            rd_act_o = ~cs_n_s_i & ~rd_s_i;
            wr_act   = ~cs_n_s_i & ~wr_s_i;
        end else begin
            rd_act_o = ~cs_n_s_i & rd_s_i &  wr_s_i;
            wr_act   = ~cs_n_s_i & rd_s_i & ~wr_s_i;
        end
    end

    // Track the write condition and keep the address and data it carried.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            wa_q     <= '0;
            wd_q     <= '0;
        end else begin
            wr_act_q <= wr_act;
            if (wr_act) begin
                wa_q <= addr_i;
                wd_q <= data_i;
            end
        end
    end

    assign wr_done_o = wr_act_q & ~wr_act;
    assign wr_addr_o = wa_q;
    assign wr_data_o = wd_q;
endmodule

// File: rtl/dual_bus_host_if.sv
// Top level of the dual-format host bus slave.
// Resynchronises host pins, resolves arrangement and convention, and issues
// one-hot register writes and tristate-controlled read data.
// Assumes the register bank presents all contents on reg_rd_vec_i.
module dual_bus_host_if
    import hbi_pkg::*;
#(
    parameter int DATA_W      = HBI_DATA_W,
    parameter int ADDR_W      = HBI_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_pin_i,
    input  logic                         irq_en_i,
    input  logic                         irq_req_i,
    input  logic                         mux_fmt_split_i,
    input  logic                         cs_n_i,
    input  logic                         ale_fmt_i,
    input  logic                         rd_ds_i,
    input  logic                         wr_rw_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            ad_i,
    output logic [DATA_W-1:0]            ad_o,
    output logic                         ad_oe_o,
    output logic                         irq_o,
    output logic                         irq_oe_o,
    output logic [(1<<ADDR_W)-1:0]       reg_wr_en_o,
    output logic [DATA_W-1:0]            reg_wr_data_o,
    input  logic [(1<<ADDR_W)*DATA_W-1:0] reg_rd_vec_i
);
    localparam int NREG   = 1 << ADDR_W;
    localparam int BUND_W = 4 + ADDR_W + DATA_W;
    localparam logic [BUND_W-1:0] BUND_RST = {1'b1, {(BUND_W-1){1'b0}}};

    logic [BUND_W-1:0] bund_raw;
    logic [BUND_W-1:0] bund_s;
    logic              cs_n_s;
    logic              ale_s;
    logic              rd_s;
    logic              wr_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] ad_s;
    logic              mux_mode;
    strobe_fmt_e       fmt;
    logic [ADDR_W-1:0] addr_cur;
    logic              rd_act;
    logic              wr_done;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [NREG-1:0]   wr_en_q;
    logic [DATA_W-1:0] wr_data_q;

    assign bund_raw = {cs_n_i, ale_fmt_i, rd_ds_i, wr_rw_i, addr_i, ad_i};

    hbi_sync #(.WIDTH(BUND_W), .STAGES(SYNC_STAGES), .RST_VAL(BUND_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bund_raw),
        .q_o   (bund_s)
    );

    assign {cs_n_s, ale_s, rd_s, wr_s, addr_s, ad_s} = bund_s;

    hbi_mode_ctl u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode_pin_i      (mode_pin_i),
        .irq_en_i        (irq_en_i),
        .irq_req_i       (irq_req_i),
        .mux_fmt_split_i (mux_fmt_split_i),
        .fmt_pin_s_i     (ale_s),
        .mux_mode_o      (mux_mode),
        .fmt_o           (fmt),
        .irq_o           (irq_o),
        .irq_oe_o        (irq_oe_o)
    );

    hbi_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mux_mode_i (mux_mode),
        .ale_s_i    (ale_s),
        .ad_lo_s_i  (ad_s[ADDR_W-1:0]),
        .addr_s_i   (addr_s),
        .addr_o     (addr_cur)
    );

    hbi_strobe_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_i     (fmt),
        .cs_n_s_i  (cs_n_s),
        .rd_s_i    (rd_s),
        .wr_s_i    (wr_s),
        .addr_i    (addr_cur),
        .data_i    (ad_s),
        .rd_act_o  (rd_act),
        .wr_done_o (wr_done),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    // Register one write-enable bit per register on write completion.
    generate
        for (genvar r = 0; r < NREG; r++) begin : g_wen
            always_ff @(posedge clk) begin
                if (!rst_n) wr_en_q[r] <= 1'b0;
                else        wr_en_q[r] <= wr_done && (wr_addr == ADDR_W'(r));
            end
        end
    endgenerate

    // Hold the write data alongside the enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_data_q <= '0;
        else if (wr_done) wr_data_q <= wr_data;
    end

    // Select read data and drive the output enable during an active read.
    always_comb begin
        ad_o    = reg_rd_vec_i[addr_cur*DATA_W +: DATA_W];
        ad_oe_o = rd_act;
    end

    assign reg_wr_en_o   = wr_en_q;
    assign reg_wr_data_o = wr_data_q;
endmodule

// File: rtl/hbi_checker.sv
// Property checker for the dual-format host bus interface, bound to the top.
module hbi_checker #(
    parameter int NREG   = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREG-1:0]   reg_wr_en_o,
    input logic              ad_oe_o,
    input logic              cs_n_s,
    input logic              irq_oe_o,
    input logic              mux_mode,
    input logic              ale_s,
    input logic [ADDR_W-1:0] addr_cur
);
    // R12: write enables are one-hot or idle
    a_r12_wen_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_wr_en_o));

    // R8: a write enable lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_wr_en_o) |=> !(|reg_wr_en_o));

    // R7: deselected device never drives the bus
    a_r7_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !ad_oe_o);

    // R10: interrupt drive stays off in multiplexed arrangement
    a_r10_irq_quiet_mux: assert property (@(posedge clk) disable iff (!rst_n)
        mux_mode |=> !irq_oe_o);

    // R4: latched address holds while the latch strobe is low
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode && !ale_s) |=> $stable(addr_cur));
endmodule

bind dual_bus_host_if hbi_checker #(.NREG(NREG), .ADDR_W(ADDR_W)) u_hbi_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en_o (reg_wr_en_o),
    .ad_oe_o     (ad_oe_o),
    .cs_n_s      (cs_n_s),
    .irq_oe_o    (irq_oe_o),
    .mux_mode    (mux_mode),
    .ale_s       (ale_s),
    .addr_cur    (addr_cur)
);

// File: tb/tb_dual_bus_host_if.sv
module tb_dual_bus_host_if;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_pin = 1'b1;
    logic         irq_en = 1'b0;
    logic         irq_req = 1'b0;
    logic         mux_fmt_split = 1'b1;
    logic         cs_n = 1'b1;
    logic         ale_fmt = 1'b1;
    logic         rd_ds = 1'b1;
    logic         wr_rw = 1'b1;
    logic [3:0]   addr = '0;
    logic [7:0]   ad_in = '0;
    logic [7:0]   ad_out;
    logic         ad_oe;
    logic         irq_o;
    logic         irq_oe;
    logic [15:0]  wen;
    logic [7:0]   wdata;
    logic [127:0] rd_vec;

    logic [7:0] bank [16];
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [3:0] a;
        logic [7:0] d;
    } wr_item_t;
    wr_item_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    dual_bus_host_if dut (
        .clk(clk), .rst_n(rst_n), .mode_pin_i(mode_pin), .irq_en_i(irq_en),
        .irq_req_i(irq_req), .mux_fmt_split_i(mux_fmt_split), .cs_n_i(cs_n),
        .ale_fmt_i(ale_fmt), .rd_ds_i(rd_ds), .wr_rw_i(wr_rw), .addr_i(addr),
        .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe), .irq_o(irq_o),
        .irq_oe_o(irq_oe), .reg_wr_en_o(wen), .reg_wr_data_o(wdata),
        .reg_rd_vec_i(rd_vec)
    );

    always_comb begin
        for (int i = 0; i < 16; i++) rd_vec[i*8 +: 8] = bank[i];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected writes as the design issues them (R8, R12)
    initial begin
        for (int i = 0; i < 16; i++) bank[i] = 8'h00;
        forever begin
            @(negedge clk);
            if (rst_n && (|wen)) begin
                int idx;
                idx = 0;
                for (int i = 0; i < 16; i++) if (wen[i]) idx = i;
                check($countones(wen) == 1, "R12 one-hot enable", wen, 32'h1 << idx);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8/R7 unexpected write pulse", {idx[7:0], wdata}, 0);
                end else begin
                    wr_item_t e;
                    e = exp_q.pop_front();
                    check(idx[3:0] == e.a && wdata == e.d, "R8 write address/data",
                          {idx[7:0], wdata}, {e.a, e.d});
                end
                bank[idx] = wdata;
            end
        end
    end

    task automatic do_reset(input logic mode);
        mode_pin = mode;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic addr_phase(input bit mux, input logic [7:0] abyte);
        if (mux) begin
            ad_in = abyte;
            ale_fmt = 1'b1;
            repeat (4) @(negedge clk);
            ale_fmt = 1'b0;
            ad_in = 8'hEE;
            repeat (3) @(negedge clk);
        end else begin
            addr = abyte[3:0];
        end
    endtask

    task automatic strobes_idle(input bit split);
        rd_ds = split ? 1'b1 : 1'b0;
        wr_rw = 1'b1;
    endtask

    // Driver: one write access; pushes the expected pulse when selected
    task automatic host_write(input bit mux, input bit split, input logic [7:0] abyte,
                              input logic [7:0] d, input bit sel);
        wr_item_t it;
        strobes_idle(split);
        addr_phase(mux, abyte);
        if (sel) begin
            it.a = abyte[3:0];
            it.d = d;
            exp_q.push_back(it);
        end
        ad_in = d;
        cs_n = ~sel;
        if (split) wr_rw = 1'b0;
        else begin wr_rw = 1'b0; rd_ds = 1'b1; end
        repeat (4) @(negedge clk);
        strobes_idle(split);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic host_read(input bit mux, input bit split, input logic [7:0] abyte,
                             input bit sel, input logic [7:0] exp, input string req);
        strobes_idle(split);
        addr_phase(mux, abyte);
        cs_n = ~sel;
        if (split) rd_ds = 1'b0;
        else begin wr_rw = 1'b1; rd_ds = 1'b1; end
        repeat (5) @(negedge clk);
        check(ad_oe == sel, {req, " R9 oe during read"}, ad_oe, sel);
        if (sel) check(ad_out == exp, {req, " R9 read data"}, ad_out, exp);
        strobes_idle(split);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        check(ad_oe == 1'b0, {req, " R9 oe released"}, ad_oe, 0);
    endtask

    initial begin
        // Separate arrangement, split convention (R1, R3, R5)
        do_reset(1'b1);
        check(ad_oe == 0 && wen == 0 && irq_oe == 0, "reset state R10", {ad_oe, irq_oe, wen}, 0);
        ale_fmt = 1'b1;
        host_write(0, 1, 8'h03, 8'h5A, 1);
        host_write(0, 1, 8'h0F, 8'hC3, 1);
        host_write(0, 1, 8'h00, 8'h11, 1);
        host_read(0, 1, 8'h03, 1, 8'h5A, "R3 R5");
        host_read(0, 1, 8'h0F, 1, 8'hC3, "R3 R5");
        host_read(0, 1, 8'h00, 1, 8'h11, "R3 R5");
        // Deselected accesses have no effect (R7)
        host_write(0, 1, 8'h03, 8'hFF, 0);
        host_read(0, 1, 8'h03, 0, 8'h00, "R7 deselected");
        host_read(0, 1, 8'h03, 1, 8'h5A, "R7 value kept");
        // Direction convention (R6)
        ale_fmt = 1'b0;
        host_write(0, 0, 8'h07, 8'h7E, 1);
        host_read(0, 0, 8'h07, 1, 8'h7E, "R6");
        // Interrupt function (R10)
        irq_en = 1'b1;
        irq_req = 1'b1;
        repeat (3) @(negedge clk);
        check(irq_oe == 1 && irq_o == 0, "R10 irq asserted", {irq_oe, irq_o}, 2'b10);
        irq_req = 1'b0;
        repeat (3) @(negedge clk);
        check(irq_oe == 1 && irq_o == 1, "R10 irq idle", {irq_oe, irq_o}, 2'b11);
        // Multiplexed arrangement via a new reset (R1, R2, R4, R11)
        do_reset(1'b0);
        check(irq_oe == 0, "R10 no irq drive when multiplexed", irq_oe, 0);
        mux_fmt_split = 1'b1;
        host_write(1, 1, 8'hF9, 8'h3C, 1);
        host_read(1, 1, 8'h09, 1, 8'h3C, "R4 R11 split");
        mux_fmt_split = 1'b0;
        host_write(1, 0, 8'h02, 8'h99, 1);
        host_read(1, 0, 8'h62, 1, 8'h99, "R4 R11 direction");
        check(irq_oe == 0, "R10 still quiet", irq_oe, 0);
        // Back to separate arrangement (R2)
        do_reset(1'b1);
        repeat (2) @(negedge clk);
        check(irq_oe == 1, "R2 re-sampled to separate", irq_oe, 1);
        ale_fmt = 1'b1;
        host_read(0, 1, 8'h09, 1, 8'h3C, "R2 R3 separate address");
        check(exp_q.size() == 0, "R8 every write pulsed once", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule